// File: doc/BRIEF.md
# Dual Scratch-Pool Job Resource Allocator

This block hands out memory slots to a job scheduler from two fixed pools. The first pool holds scratch areas: five contiguous blocks of 44 words each. The second pool holds context-save sets: eight blocks, each sized to hold one saved interpreter context. A job-start request carries two flags that say whether the job needs a scratch area, a context set, both, or neither. The block decides in one step. It either grants every slot the request needs or grants nothing. For each granted slot it returns the slot index and the base word address.

A slot can be given back at any time, for example when its job ends or when the job is done with its scratch space early. Each pool has its own release port. When a request cannot be met, the response reports a pool-specific alarm code. Each pool also reports its free count and its high-water mark of slots in use. A sticky error flag records any release of a slot that was not held.

Top module: `jobpool_alloc`

## Requirements
- R1: After reset both pools are empty of users. The scratch free count is 5, the context free count is 8, both high-water marks are 0, `dfree_err` is 0 and `rsp_valid` is 0.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low otherwise. When `rsp_valid` is low, `rsp_ok`, `rsp_alarm`, both grant flags, both indices and both bases are 0. A grant flag that is 0 comes with index 0 and base 0.
- R3: A granted slot is always the lowest-numbered free slot of its pool. Scratch slot k has base SCRATCH_BASE + 44·k (default SCRATCH_BASE 768). Context slot k has base CTX_BASE + 12·k (default CTX_BASE 64).
- R4: A request that needs neither pool always succeeds, with `rsp_ok`=1, alarm 0 and no slot taken.
- R5: A request for a scratch area when none is free is refused: `rsp_ok`=0, `rsp_alarm`=1202 (decimal), and neither pool changes.
- R6: A request for a context set when none is free is refused with `rsp_alarm`=1201 (decimal), and neither pool changes.
- R7: A request that needs both pools is granted only if both have a free slot. Otherwise nothing is taken from either pool. The context pool is checked first, so 1201 is reported whenever the context pool is exhausted, and 1202 only when the context pool has room but the scratch pool does not.
- R8: A released slot is free from the next cycle on. A release and a request in the same cycle act release-first, so the request may receive the slot being released.
- R9: Releasing a slot that is not held, or giving an index at or above the pool size, sets `dfree_err`. That flag stays set until reset, and the pool is left unchanged.
- R10: The free count shows the state after each clock edge. The high-water mark shows the largest number of slots in use since reset or since the last `hwm_clear`. A `hwm_clear` loads the in-use count that results from that cycle's operations.
- R11: The two pools are independent. An operation that concerns only one pool leaves the other pool's free count and high-water mark unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Job-start request strobe |
| req_need_scr | input | 1 | Request needs a scratch area |
| req_need_ctx | input | 1 | Request needs a context set |
| scr_rel_valid | input | 1 | Release a scratch slot |
| scr_rel_idx | input | 3 | Scratch slot being released |
| ctx_rel_valid | input | 1 | Release a context slot |
| ctx_rel_idx | input | 3 | Context slot being released |
| hwm_clear | input | 1 | Reload both high-water marks with the current use |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Request granted |
| rsp_alarm | output | 11 | Exhaustion alarm code, 0 if none |
| rsp_scr_grant | output | 1 | A scratch slot was granted |
| rsp_scr_idx | output | 3 | Granted scratch slot |
| rsp_scr_base | output | 12 | Base word address of the scratch slot |
| rsp_ctx_grant | output | 1 | A context slot was granted |
| rsp_ctx_idx | output | 3 | Granted context slot |
| rsp_ctx_base | output | 12 | Base word address of the context slot |
| scr_free_cnt | output | 3 | Free scratch slots |
| ctx_free_cnt | output | 4 | Free context slots |
| scr_hwm | output | 3 | Scratch high-water mark |
| ctx_hwm | output | 4 | Context high-water mark |
| dfree_err | output | 1 | Sticky bad-release flag |

## Verification
The case that is hardest to reach is a request for both pools that meets a partial shortage: one pool is full and the other is not. The block must then take nothing and report the right code. The stimulus fills both pools on purpose and then frees exactly one slot in one pool. It sends a dual request, then repeats with the roles of the two pools swapped. Release-first ordering is driven directly by pairing a release and a request in the same cycle while the pool is full. A long pseudo-random sweep then mixes every request type, release and clear against a reference model of the requirements held in the bench.

// File: rtl/jobpool_pkg.sv
package jobpool_pkg;

    // alarm code width and the "no alarm" value
    localparam int ALARM_W = 11;
    localparam logic [ALARM_W-1:0] ALARM_NONE = '0;

    // default exhaustion codes for the two pools
    localparam int DEF_SCR_ALARM = 1202;
    localparam int DEF_CTX_ALARM = 1201;

    // width of a counter that must hold 0..n
    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

    // width of an index that must hold 0..n-1
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/jobpool_slot_pool.sv
module jobpool_slot_pool
    import jobpool_pkg::*;
#(
    parameter int N      = 5,
    parameter int WORDS  = 44,
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE = '0,
    localparam int IW = idx_bits(N),
    localparam int CW = cnt_bits(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel_valid,
    input  logic [IW-1:0]     rel_idx,
    input  logic              take,
    input  logic              hwm_clear,
    output logic              avail,
    output logic [IW-1:0]     pick_idx,
    output logic [ADDR_W-1:0] pick_base,
    output logic              rel_bad,
    output logic [CW-1:0]     free_cnt,
    output logic [CW-1:0]     hwm
);

    typedef struct packed {
        logic [N-1:0]  busy;
        logic [CW-1:0] free;
        logic [CW-1:0] hwm;
    } pool_st_t;

    pool_st_t     st_q, st_d;
    logic [N-1:0] busy_rel;
    logic         hit;
    logic [CW-1:0] used_n;

    always_comb begin
        // releases are applied before any take
        busy_rel = st_q.busy;
        hit      = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (rel_valid && (rel_idx == IW'(i)) && st_q.busy[i]) begin
                busy_rel[i] = 1'b0;
                hit         = 1'b1;
            end
        end
        rel_bad = rel_valid && !hit;

        // lowest-numbered free slot wins
        avail    = 1'b0;
        pick_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy_rel[i]) begin
                avail    = 1'b1;
                pick_idx = IW'(i);
            end
        end
        pick_base = BASE + ADDR_W'(WORDS * int'(pick_idx));

        st_d      = st_q;
        st_d.busy = busy_rel;
        for (int i = 0; i < N; i++) begin
            if (take && avail && (pick_idx == IW'(i))) begin
                st_d.busy[i] = 1'b1;
            end
        end

        used_n = '0;
        for (int i = 0; i < N; i++) begin
            used_n = used_n + CW'(st_d.busy[i]);
        end
        st_d.free = CW'(N) - used_n;
        if (hwm_clear || (used_n > st_q.hwm)) begin
            st_d.hwm = used_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.busy <= '0;
            st_q.free <= CW'(N);
            st_q.hwm  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign free_cnt = st_q.free;
    assign hwm      = st_q.hwm;

    // a take is only ever requested when this pool has room
    assert_take_has_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> avail);

    // the mark never lies below the current use
    assert_hwm_covers_use_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(N) - free_cnt) <= hwm);

    assert_free_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CW'(N));

    // a bad release with no take leaves the pool as it was
    assert_bad_release_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_bad && !take) |=> (free_cnt == $past(free_cnt)));

endmodule

// File: rtl/jobpool_decide.sv
module jobpool_decide
    import jobpool_pkg::*;
#(
    parameter logic [ALARM_W-1:0] SCR_CODE = ALARM_W'(DEF_SCR_ALARM),
    parameter logic [ALARM_W-1:0] CTX_CODE = ALARM_W'(DEF_CTX_ALARM)
) (
    input  logic               req_valid,
    input  logic               need_scr,
    input  logic               need_ctx,
    input  logic               scr_avail,
    input  logic               ctx_avail,
    output logic               grant,
    output logic               take_scr,
    output logic               take_ctx,
    output logic [ALARM_W-1:0] alarm
);

    logic scr_short, ctx_short;

    always_comb begin
        ctx_short = need_ctx && !ctx_avail;
        scr_short = need_scr && !scr_avail;
        grant     = req_valid && !ctx_short && !scr_short;
        take_scr  = grant && need_scr;
        take_ctx  = grant && need_ctx;
        alarm     = ALARM_NONE;
        if (req_valid) begin
            // context pool is examined first
            if (ctx_short) begin
                alarm = CTX_CODE;
            end else if (scr_short) begin
                alarm = SCR_CODE;
            end
        end
    end

endmodule

// File: rtl/jobpool_alloc.sv
module jobpool_alloc
    import jobpool_pkg::*;
#(
    parameter int SCR_N     = 5,
    parameter int SCR_WORDS = 44,
    parameter int CTX_N     = 8,
    parameter int CTX_WORDS = 12,
    parameter int ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] SCRATCH_BASE = ADDR_W'(768),
    parameter logic [ADDR_W-1:0] CTX_BASE     = ADDR_W'(64),
    parameter logic [ALARM_W-1:0] SCR_ALARM   = ALARM_W'(DEF_SCR_ALARM),
    parameter logic [ALARM_W-1:0] CTX_ALARM   = ALARM_W'(DEF_CTX_ALARM),
    localparam int SCR_IW = idx_bits(SCR_N),
    localparam int CTX_IW = idx_bits(CTX_N),
    localparam int SCR_CW = cnt_bits(SCR_N),
    localparam int CTX_CW = cnt_bits(CTX_N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_need_scr,
    input  logic               req_need_ctx,
    input  logic               scr_rel_valid,
    input  logic [SCR_IW-1:0]  scr_rel_idx,
    input  logic               ctx_rel_valid,
    input  logic [CTX_IW-1:0]  ctx_rel_idx,
    input  logic               hwm_clear,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic [ALARM_W-1:0] rsp_alarm,
    output logic               rsp_scr_grant,
    output logic [SCR_IW-1:0]  rsp_scr_idx,
    output logic [ADDR_W-1:0]  rsp_scr_base,
    output logic               rsp_ctx_grant,
    output logic [CTX_IW-1:0]  rsp_ctx_idx,
    output logic [ADDR_W-1:0]  rsp_ctx_base,
    output logic [SCR_CW-1:0]  scr_free_cnt,
    output logic [CTX_CW-1:0]  ctx_free_cnt,
    output logic [SCR_CW-1:0]  scr_hwm,
    output logic [CTX_CW-1:0]  ctx_hwm,
    output logic               dfree_err
);

    typedef struct packed {
        logic               valid;
        logic               ok;
        logic [ALARM_W-1:0] alarm;
        logic               scr_g;
        logic [SCR_IW-1:0]  scr_idx;
        logic [ADDR_W-1:0]  scr_base;
        logic               ctx_g;
        logic [CTX_IW-1:0]  ctx_idx;
        logic [ADDR_W-1:0]  ctx_base;
        logic               err;
    } rsp_st_t;

    rsp_st_t r_q, r_d;

    logic               scr_avail, ctx_avail;
    logic [SCR_IW-1:0]  scr_pick;
    logic [CTX_IW-1:0]  ctx_pick;
    logic [ADDR_W-1:0]  scr_pbase, ctx_pbase;
    logic               scr_bad, ctx_bad;
    logic               grant, take_scr, take_ctx;
    logic [ALARM_W-1:0] alarm;

    jobpool_slot_pool #(
        .N(SCR_N), .WORDS(SCR_WORDS), .ADDR_W(ADDR_W), .BASE(SCRATCH_BASE)
    ) u_scr_pool (
        .clk(clk), .rst_n(rst_n),
        .rel_valid(scr_rel_valid), .rel_idx(scr_rel_idx),
        .take(take_scr), .hwm_clear(hwm_clear),
        .avail(scr_avail), .pick_idx(scr_pick), .pick_base(scr_pbase),
        .rel_bad(scr_bad), .free_cnt(scr_free_cnt), .hwm(scr_hwm)
    );

    jobpool_slot_pool #(
        .N(CTX_N), .WORDS(CTX_WORDS), .ADDR_W(ADDR_W), .BASE(CTX_BASE)
    ) u_ctx_pool (
        .clk(clk), .rst_n(rst_n),
        .rel_valid(ctx_rel_valid), .rel_idx(ctx_rel_idx),
        .take(take_ctx), .hwm_clear(hwm_clear),
        .avail(ctx_avail), .pick_idx(ctx_pick), .pick_base(ctx_pbase),
        .rel_bad(ctx_bad), .free_cnt(ctx_free_cnt), .hwm(ctx_hwm)
    );

    jobpool_decide #(
        .SCR_CODE(SCR_ALARM), .CTX_CODE(CTX_ALARM)
    ) u_decide (
        .req_valid(req_valid), .need_scr(req_need_scr), .need_ctx(req_need_ctx),
        .scr_avail(scr_avail), .ctx_avail(ctx_avail),
        .grant(grant), .take_scr(take_scr), .take_ctx(take_ctx), .alarm(alarm)
    );

    always_comb begin
        r_d          = '0;
        r_d.err      = r_q.err || scr_bad || ctx_bad;
        r_d.valid    = req_valid;
        r_d.ok       = grant;
        r_d.alarm    = alarm;
        r_d.scr_g    = take_scr;
        r_d.ctx_g    = take_ctx;
        if (take_scr) begin
            r_d.scr_idx  = scr_pick;
            r_d.scr_base = scr_pbase;
        end
        if (take_ctx) begin
            r_d.ctx_idx  = ctx_pick;
            r_d.ctx_base = ctx_pbase;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid     = r_q.valid;
    assign rsp_ok        = r_q.ok;
    assign rsp_alarm     = r_q.alarm;
    assign rsp_scr_grant = r_q.scr_g;
    assign rsp_scr_idx   = r_q.scr_idx;
    assign rsp_scr_base  = r_q.scr_base;
    assign rsp_ctx_grant = r_q.ctx_g;
    assign rsp_ctx_idx   = r_q.ctx_idx;
    assign rsp_ctx_base  = r_q.ctx_base;
    assign dfree_err     = r_q.err;

    assert_rsp_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_grant_clean_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> (rsp_alarm == ALARM_NONE));

    assert_refusal_coded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> ((rsp_alarm == SCR_ALARM) || (rsp_alarm == CTX_ALARM)));

    assert_refusal_takes_nothing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ok |-> (!rsp_scr_grant && !rsp_ctx_grant));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dfree_err |=> dfree_err);

    assert_scr_grant_lowers_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_scr && !scr_rel_valid) |=> (scr_free_cnt == $past(scr_free_cnt) - 1'b1));

endmodule

// File: tb/jobpool_alloc_bench.sv
module jobpool_alloc_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_need_scr, req_need_ctx;
    logic        scr_rel_valid, ctx_rel_valid, hwm_clear;
    logic [2:0]  scr_rel_idx, ctx_rel_idx;
    logic        rsp_valid, rsp_ok, rsp_scr_grant, rsp_ctx_grant, dfree_err;
    logic [10:0] rsp_alarm;
    logic [2:0]  rsp_scr_idx, rsp_ctx_idx;
    logic [11:0] rsp_scr_base, rsp_ctx_base;
    logic [2:0]  scr_free_cnt, scr_hwm;
    logic [3:0]  ctx_free_cnt, ctx_hwm;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    bit [4:0] m_sb;
    bit [7:0] m_cb;
    int       m_shwm, m_chwm;
    bit       m_err;

    always #2.5 clk = ~clk;

    jobpool_alloc u_jobpool_alloc (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_need_scr(req_need_scr), .req_need_ctx(req_need_ctx),
        .scr_rel_valid(scr_rel_valid), .scr_rel_idx(scr_rel_idx),
        .ctx_rel_valid(ctx_rel_valid), .ctx_rel_idx(ctx_rel_idx),
        .hwm_clear(hwm_clear),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_alarm(rsp_alarm),
        .rsp_scr_grant(rsp_scr_grant), .rsp_scr_idx(rsp_scr_idx), .rsp_scr_base(rsp_scr_base),
        .rsp_ctx_grant(rsp_ctx_grant), .rsp_ctx_idx(rsp_ctx_idx), .rsp_ctx_base(rsp_ctx_base),
        .scr_free_cnt(scr_free_cnt), .ctx_free_cnt(ctx_free_cnt),
        .scr_hwm(scr_hwm), .ctx_hwm(ctx_hwm), .dfree_err(dfree_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int low_free(input bit [7:0] busy, input int n);
        for (int i = 0; i < n; i++) if (!busy[i]) return i;
        return -1;
    endfunction

    function automatic int used(input bit [7:0] busy);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(busy[i]);
        return c;
    endfunction

    task automatic idle_inputs();
        req_valid = 0; req_need_scr = 0; req_need_ctx = 0;
        scr_rel_valid = 0; scr_rel_idx = '0;
        ctx_rel_valid = 0; ctx_rel_idx = '0;
        hwm_clear = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_sb = '0; m_cb = '0; m_shwm = 0; m_chwm = 0; m_err = 0;
    endtask

    // one cycle of stimulus, then compare every output with the model
    task automatic step(input string tag, input bit rq, input bit ns, input bit nc,
                        input bit rsv, input int rsi, input bit rcv, input int rci,
                        input bit clr);
        int e_ok, e_al, e_sg, e_si, e_sb, e_cg, e_ci, e_cb, sf, cf;
        req_valid = rq; req_need_scr = ns; req_need_ctx = nc;
        scr_rel_valid = rsv; scr_rel_idx = 3'(rsi);
        ctx_rel_valid = rcv; ctx_rel_idx = 3'(rci);
        hwm_clear = clr;
        @(negedge clk);
        // releases first (R8), bad ones flag only (R9)
        if (rsv) begin
            if (rsi < 5 && m_sb[rsi]) m_sb[rsi] = 0; else m_err = 1;
        end
        if (rcv) begin
            if (m_cb[rci]) m_cb[rci] = 0; else m_err = 1;
        end
        e_ok = 0; e_al = 0; e_sg = 0; e_si = 0; e_sb = 0; e_cg = 0; e_ci = 0; e_cb = 0;
        if (rq) begin
            sf = low_free({3'b0, m_sb}, 5);
            cf = low_free(m_cb, 8);
            if (nc && cf < 0)      e_al = 1201;
            else if (ns && sf < 0) e_al = 1202;
            else begin
                e_ok = 1;
                if (ns) begin e_sg = 1; e_si = sf; e_sb = 768 + 44 * sf; m_sb[sf] = 1; end
                if (nc) begin e_cg = 1; e_ci = cf; e_cb = 64 + 12 * cf; m_cb[cf] = 1; end
            end
        end
        if (clr || used({3'b0, m_sb}) > m_shwm) m_shwm = used({3'b0, m_sb});
        if (clr || used(m_cb) > m_chwm) m_chwm = used(m_cb);
        chk(tag, "rsp_valid", int'(rsp_valid), int'(rq));
        chk(tag, "rsp_ok", int'(rsp_ok), e_ok);
        chk(tag, "rsp_alarm", int'(rsp_alarm), e_al);
        chk(tag, "scr_grant", int'(rsp_scr_grant), e_sg);
        chk(tag, "scr_idx R3", int'(rsp_scr_idx), e_si);
        chk(tag, "scr_base R3", int'(rsp_scr_base), e_sb);
        chk(tag, "ctx_grant", int'(rsp_ctx_grant), e_cg);
        chk(tag, "ctx_idx R3", int'(rsp_ctx_idx), e_ci);
        chk(tag, "ctx_base R3", int'(rsp_ctx_base), e_cb);
        chk(tag, "scr_free R10", int'(scr_free_cnt), 5 - used({3'b0, m_sb}));
        chk(tag, "ctx_free R10", int'(ctx_free_cnt), 8 - used(m_cb));
        chk(tag, "scr_hwm R10", int'(scr_hwm), m_shwm);
        chk(tag, "ctx_hwm R10", int'(ctx_hwm), m_chwm);
        chk(tag, "dfree_err R9", int'(dfree_err), int'(m_err));
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit [31:0] lf;
        do_reset();
        // R1 reset state
        chk("R1", "rsp_valid", int'(rsp_valid), 0);
        chk("R1", "scr_free", int'(scr_free_cnt), 5);
        chk("R1", "ctx_free", int'(ctx_free_cnt), 8);
        chk("R1", "scr_hwm", int'(scr_hwm), 0);
        chk("R1", "ctx_hwm", int'(ctx_hwm), 0);
        chk("R1", "dfree_err", int'(dfree_err), 0);

        step("R4", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
        // fill scratch one by one, then overflow
        for (int i = 0; i < 5; i++) step("R3", 1, 1, 0, 0, 0, 0, 0, 0);
        step("R5", 1, 1, 0, 0, 0, 0, 0, 0);
        chk("R5", "literal alarm", int'(rsp_alarm), 1202);
        step("R11", 1, 0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 7; i++) step("R3", 1, 0, 1, 0, 0, 0, 0, 0);
        step("R6", 1, 0, 1, 0, 0, 0, 0, 0);
        chk("R6", "literal alarm", int'(rsp_alarm), 1201);
        step("R4", 1, 0, 0, 0, 0, 0, 0, 0);
        // both pools full: context reported first
        step("R7", 1, 1, 1, 0, 0, 0, 0, 0);
        step("R7", 0, 0, 0, 1, 2, 0, 0, 0);
        step("R7", 1, 1, 1, 0, 0, 0, 0, 0);
        chk("R7", "scratch kept free", int'(scr_free_cnt), 1);
        step("R7", 0, 0, 0, 0, 0, 1, 5, 0);
        step("R7", 1, 1, 1, 0, 0, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 0, 1, 3, 0);
        step("R7", 1, 1, 1, 0, 0, 0, 0, 0);
        chk("R7", "context kept free", int'(ctx_free_cnt), 1);
        // release-first in one cycle while full
        step("R8", 1, 1, 0, 1, 1, 0, 0, 0);
        chk("R8", "reused idx", int'(rsp_scr_idx), 1);
        step("R8", 1, 0, 1, 0, 0, 1, 6, 0);
        step("R8", 1, 1, 1, 1, 4, 1, 0, 0);
        // high-water clear
        step("R10", 0, 0, 0, 1, 0, 0, 0, 0);
        step("R10", 0, 0, 0, 1, 3, 1, 1, 1);
        chk("R10", "scr_hwm after clear", int'(scr_hwm), 3);
        // double and out-of-range releases
        step("R9", 0, 0, 0, 1, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 1, 6, 0, 0, 0);
        do_reset();
        step("R9", 0, 0, 0, 0, 0, 1, 2, 0);
        step("R9", 1, 1, 1, 0, 0, 0, 0, 0);

        // pseudo-random sweep over every request type and release pattern
        do_reset();
        lf = 32'h1ACE_0F35;
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step("R11", lf[2] | lf[3], lf[0], lf[1],
                 lf[4] & lf[5], int'(lf[8:6]) % ((n < 1500) ? 5 : 8),
                 lf[9] & lf[10], int'(lf[13:11]),
                 lf[17:14] == 4'd0);
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule